// File: doc/BRIEF.md
# Page Fault Detection and Reporting

This block examines a single linear-address translation attempt and decides whether it must raise a page fault. The caller supplies the entry bits of both translation levels directly: a present bit, a user-accessible bit and a writable bit for the directory level and for the table level. It also supplies the privilege of the access, its direction, the linear address and a paging-enable bit. Table walking, translation caching and physical memory stay outside the block.

When a request strobe arrives with paging enabled, the block checks presence at both levels and then access rights. On a fault it pulses a fault flag for one cycle and drives vector number 14. It also updates a three-field error code. The faulting linear address goes into a fault-address register, which keeps its value until the next fault. A handler reads the code and the address to find the cause and to recover.

Top module: `pf_fault_unit`

## Requirements
- R1: After reset the fault flag is 0, the error code is 0, the fault-address register is 0 and the vector output is 0.
- R2: A request made while paging is disabled never faults, and it leaves the error code and the fault-address register unchanged.
- R3: With paging enabled, a request where the directory-level or the table-level present bit is 0 raises the fault flag on the cycle after the request, with error-code bit 0 equal to 0.
- R4: A user-mode request where either level has its user bit at 0 faults with error-code bit 0 equal to 1 (rights violation).
- R5: A user-mode write where either level has its writable bit at 0 faults with error-code bit 0 equal to 1. A user-mode read needs no writable bit.
- R6: A supervisor-mode request to an entry present at both levels never faults, whatever the user and writable bits are.
- R7: When an entry is absent and a rights violation also exists, error-code bit 0 is 0 (not present takes precedence).
- R8: In the error code, bit 1 is 1 for a write and bit 2 is 1 for user mode. Bits 31 to 3 are always 0.
- R9: On a fault the fault-address register takes the request's linear address. It holds that value across requests that do not fault.
- R10: The fault flag is a one-cycle pulse that follows only a request strobe. The vector output reads 14 while the flag is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Translation attempt strobe, one cycle per attempt |
| pg_en_i | input | 1 | Paging enable; when 0 no fault is possible |
| lin_addr_i | input | 32 | Linear address of the access |
| ent_present_i | input | 2 | Present bits; bit 0 directory level, bit 1 table level |
| ent_user_i | input | 2 | User-accessible bits; bit 0 directory, bit 1 table |
| ent_write_i | input | 2 | Writable bits; bit 0 directory, bit 1 table |
| user_mode_i | input | 1 | 1 for a user-mode access, 0 for supervisor |
| write_acc_i | input | 1 | 1 for a write, 0 for a read |
| fault_o | output | 1 | One-cycle page-fault pulse |
| err_code_o | output | 32 | Error code of the latest fault |
| fault_addr_o | output | 32 | Linear address of the latest fault |
| vector_o | output | 8 | Exception vector, 14 while fault_o is high |

## Verification
The assertions assume that every entry, mode and direction bit is a known value on any cycle where the request strobe is high. They also assume the strobe is sampled on one clock edge per attempt. The stimulus drives all inputs on the falling edge, raises the strobe for exactly one cycle per attempt, and lowers it between attempts. Each check therefore sees one request followed by a cycle with no request.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam int unsigned PF_VECTOR    = 14;
  localparam int unsigned BIT_RIGHTS   = 0;
  localparam int unsigned BIT_WRITE    = 1;
  localparam int unsigned BIT_USER     = 2;

  typedef enum logic [1:0] {
    PF_KIND_NONE   = 2'd0,
    PF_KIND_ABSENT = 2'd1,
    PF_KIND_RIGHTS = 2'd2
  } pf_kind_e;

  // Presence wins over rights; paging off means no fault at all.
  function automatic pf_kind_e pf_classify(input logic pg_en,
                                           input logic any_absent,
                                           input logic any_deny);
    if (!pg_en)          return PF_KIND_NONE;
    else if (any_absent) return PF_KIND_ABSENT;
    else if (any_deny)   return PF_KIND_RIGHTS;
    else                 return PF_KIND_NONE;
  endfunction

  // Builds the low three fields of the error code.
  function automatic logic [2:0] pf_code_fields(input pf_kind_e kind,
                                                input logic is_user,
                                                input logic is_write);
    logic [2:0] f;
    f = '0;
    f[BIT_RIGHTS] = (kind == PF_KIND_RIGHTS);
    f[BIT_WRITE]  = is_write;
    f[BIT_USER]   = is_user;
    return f;
  endfunction

endpackage

// File: rtl/pf_level_check.sv
module pf_level_check #(
  parameter int unsigned LEVELS = 2
) (
  input  logic [LEVELS-1:0] present_i,
  input  logic [LEVELS-1:0] user_ok_i,
  input  logic [LEVELS-1:0] write_ok_i,
  input  logic              user_mode_i,
  input  logic              write_acc_i,
  output logic              any_absent_o,
  output logic              any_deny_o
);

  logic [LEVELS-1:0] absent_lvl;
  logic [LEVELS-1:0] deny_lvl;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign absent_lvl[g] = ~present_i[g];
    // Supervisor accesses bypass the rights check at every level.
    assign deny_lvl[g]   = user_mode_i &
                           (~user_ok_i[g] | (write_acc_i & ~write_ok_i[g]));
  end

  assign any_absent_o = |absent_lvl;
  assign any_deny_o   = |deny_lvl;

endmodule

// File: rtl/pf_code_build.sv
module pf_code_build #(
  parameter int unsigned CODE_W = 32
) (
  input  logic              pg_en_i,
  input  logic              any_absent_i,
  input  logic              any_deny_i,
  input  logic              user_mode_i,
  input  logic              write_acc_i,
  output logic              is_fault_o,
  output logic [CODE_W-1:0] code_o
);
  import pf_pkg::*;

  localparam int unsigned FIELD_W = 3;

  pf_kind_e kind;

  always_comb begin
    kind       = pf_classify(pg_en_i, any_absent_i, any_deny_i);
    is_fault_o = (kind != PF_KIND_NONE);
    code_o     = '0;
    code_o[FIELD_W-1:0] = pf_code_fields(kind, user_mode_i, write_acc_i);
  end

endmodule

// File: rtl/pf_fault_unit.sv
module pf_fault_unit #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CODE_W = 32,
  parameter int unsigned LEVELS = 2,
  parameter int unsigned VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              pg_en_i,
  input  logic [ADDR_W-1:0] lin_addr_i,
  input  logic [LEVELS-1:0] ent_present_i,
  input  logic [LEVELS-1:0] ent_user_i,
  input  logic [LEVELS-1:0] ent_write_i,
  input  logic              user_mode_i,
  input  logic              write_acc_i,
  output logic              fault_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [VEC_W-1:0]  vector_o
);
  import pf_pkg::*;

  localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(PF_VECTOR);

  // Named internal events
  logic              any_absent;
  logic              any_deny;
  logic              is_fault;
  logic [CODE_W-1:0] next_code;
  logic              flt_capture;

  pf_level_check #(.LEVELS(LEVELS)) i_lvl (
    .present_i    (ent_present_i),
    .user_ok_i    (ent_user_i),
    .write_ok_i   (ent_write_i),
    .user_mode_i  (user_mode_i),
    .write_acc_i  (write_acc_i),
    .any_absent_o (any_absent),
    .any_deny_o   (any_deny)
  );

  pf_code_build #(.CODE_W(CODE_W)) i_code (
    .pg_en_i      (pg_en_i),
    .any_absent_i (any_absent),
    .any_deny_i   (any_deny),
    .user_mode_i  (user_mode_i),
    .write_acc_i  (write_acc_i),
    .is_fault_o   (is_fault),
    .code_o       (next_code)
  );

  assign flt_capture = req_i & is_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_o      <= 1'b0;
      err_code_o   <= '0;
      fault_addr_o <= '0;
    end else begin
      fault_o <= flt_capture;
      if (flt_capture) begin
        err_code_o   <= next_code;
        fault_addr_o <= lin_addr_i;
      end
    end
  end

  assign vector_o = fault_o ? VEC_VAL : '0;

  // R2: paging disabled means no fault on the following cycle
  assert_no_fault_unpaged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !pg_en_i) |=> !fault_o);

  // R3 / R7: an absent entry gives a fault coded as not-present
  assert_absent_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && pg_en_i && !(&ent_present_i)) |=> (fault_o && !err_code_o[BIT_RIGHTS]));

  // R6: supervisor access to a fully present entry never faults
  assert_sup_no_rights_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !user_mode_i && (&ent_present_i)) |=> !fault_o);

  // R8: upper error-code bits stay clear
  assert_code_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_code_o[CODE_W-1:3] == '0);

  // R9: fault address holds when nothing faults
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_capture |=> $stable(fault_addr_o));

  // R10: no fault pulse without a preceding strobe
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !fault_o);

  // R10: vector reads 14 during the pulse
  assert_vector_val_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (vector_o == VEC_VAL));

endmodule

// File: tb/test_pf_fault_unit.sv
module test_pf_fault_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic        pg_en_i = 1'b0;
  logic [31:0] lin_addr_i = '0;
  logic [1:0]  ent_present_i = '0;
  logic [1:0]  ent_user_i = '0;
  logic [1:0]  ent_write_i = '0;
  logic        user_mode_i = 1'b0;
  logic        write_acc_i = 1'b0;
  logic        fault_o;
  logic [31:0] err_code_o;
  logic [31:0] fault_addr_o;
  logic [7:0]  vector_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pf_fault_unit i_pf_fault_unit (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .pg_en_i(pg_en_i),
    .lin_addr_i(lin_addr_i), .ent_present_i(ent_present_i),
    .ent_user_i(ent_user_i), .ent_write_i(ent_write_i),
    .user_mode_i(user_mode_i), .write_acc_i(write_acc_i),
    .fault_o(fault_o), .err_code_o(err_code_o),
    .fault_addr_o(fault_addr_o), .vector_o(vector_o)
  );

  // Vector: [12]pg [11]dir_p [10]dir_u [9]dir_w [8]tbl_p [7]tbl_u [6]tbl_w
  //         [5]user [4]write [3]exp_fault [2:0]exp_code{user,write,rights}
  localparam int NVEC = 12;
  localparam logic [12:0] VECS [NVEC] = '{
    13'b1_111_111_11_0_000,  // R4 R5 full rights user write: no fault
    13'b0_011_011_11_0_000,  // R2 paging off with absent entries
    13'b1_011_111_00_1_000,  // R3 directory absent, supervisor read
    13'b1_111_011_11_1_110,  // R3 table absent, user write
    13'b1_101_111_10_1_101,  // R4 directory user bit clear
    13'b1_111_110_11_1_111,  // R5 table not writable, user write
    13'b1_111_110_10_0_000,  // R5 table not writable, user read ok
    13'b1_100_111_01_0_000,  // R6 supervisor write, no rights
    13'b1_011_101_10_1_100,  // R7 absent wins over user clear
    13'b1_110_111_11_1_111,  // R5 directory not writable
    13'b1_111_101_01_0_000,  // R6 supervisor write, table user clear
    13'b1_111_011_01_1_010   // R3 table absent, supervisor write
  };

  function automatic string tag_of(int i);
    case (i)
      1: return "R2";
      2, 3, 11: return "R3";
      4: return "R4";
      5, 6, 9: return "R5";
      7, 10: return "R6";
      8: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic pg, logic [1:0] p, logic [1:0] u, logic [1:0] w,
                       logic usr, logic wr, logic [31:0] a, logic strobe);
    @(negedge clk);
    pg_en_i = pg; ent_present_i = p; ent_user_i = u; ent_write_i = w;
    user_mode_i = usr; write_acc_i = wr; lin_addr_i = a; req_i = strobe;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] exp_addr;
    logic [31:0] exp_code;
    logic [31:0] a;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 fault", {31'd0, fault_o}, 32'd0);
    check("R1 code", err_code_o, 32'd0);
    check("R1 addr", fault_addr_o, 32'd0);
    check("R1 vector", {24'd0, vector_o}, 32'd0);
    rst_n = 1'b1;
    exp_addr = '0;
    exp_code = '0;

    for (int i = 0; i < NVEC; i++) begin
      logic [12:0] v;
      v = VECS[i];
      a = 32'h1000_0007 + i * 32'h0001_1234;
      issue(v[12], {v[8], v[11]}, {v[7], v[10]}, {v[6], v[9]}, v[5], v[4], a, 1'b1);
      if (v[3]) begin
        exp_addr = a;
        exp_code = {29'd0, v[2:0]};
      end
      check({tag_of(i), " fault"}, {31'd0, fault_o}, {31'd0, v[3]});
      check({tag_of(i), " R8 code"}, err_code_o, exp_code);
      check({tag_of(i), " R9 addr"}, fault_addr_o, exp_addr);
      check({tag_of(i), " R10 vector"}, {24'd0, vector_o}, v[3] ? 32'd14 : 32'd0);
      @(negedge clk);
      check("R10 pulse ends", {31'd0, fault_o}, 32'd0);
    end

    // R10: fault-worthy inputs without strobe
    issue(1'b1, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 32'hDEAD_0000, 1'b0);
    check("R10 no strobe", {31'd0, fault_o}, 32'd0);
    check("R9 addr kept", fault_addr_o, exp_addr);

    // R9: new fault overwrites, then non-fault keeps
    issue(1'b1, 2'b01, 2'b11, 2'b11, 1'b0, 1'b0, 32'hFFFF_F000, 1'b1);
    check("R3 edge addr fault", {31'd0, fault_o}, 32'd1);
    check("R9 overwrite", fault_addr_o, 32'hFFFF_F000);
    check("R8 sup read code", err_code_o, 32'd0);
    issue(1'b1, 2'b11, 2'b11, 2'b11, 1'b1, 1'b1, 32'h0000_1234, 1'b1);
    check("R9 hold", fault_addr_o, 32'hFFFF_F000);

    // R2: paging off keeps code and addr
    issue(1'b0, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 32'h0BAD_0BAD, 1'b1);
    check("R2 no fault", {31'd0, fault_o}, 32'd0);
    check("R2 addr unchanged", fault_addr_o, 32'hFFFF_F000);

    // R1: reset again clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset addr", fault_addr_o, 32'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule